// File: doc/BRIEF.md
# Looping Pattern Playback Sequencer

This block replays a stored pattern onto one cable at one word per clock, in an endless loop. A host fills a single-port pattern memory of 24-bit words while host access is enabled. Host access is then dropped, a loop count is written, and streaming is enabled. The sequencer reads the memory from address 0 upward and wraps back to 0 after the last looped location. Each word passes through a registered output stage that drives the cable. The loop count is programmed as the number of looped locations minus three, so a count of 3 repeats a six-word pattern. Memory depth is set by `ADDR_W`; 17 gives the full 128K-word store, and the default of 10 keeps elaboration small.

A three-state controller governs playback. IDLE holds the address at 0. ARM holds address 0 while waiting for a synchronisation pulse. RUN advances the address each clock. Its transitions are:
- *start* (IDLE to RUN): streaming is enabled and no sync wait is requested.
- *arm* (IDLE to ARM): streaming is enabled and a sync wait is requested.
- *fire* (ARM to RUN): a sync pulse arrives.
- *halt* (ARM or RUN to IDLE): streaming is disabled or host access is taken.
- *soft reset* (any state to IDLE): the software reset bit is set. This transition has the highest priority.

Host access and playback never share the memory at the same time.

The `INVERT` parameter sets the cable type. Inverted cables idle with every bit high. Non-inverted cables idle with every bit low. The filler positions in each word are always forced to the channel's idle level. The signal bits pass through unchanged: strobe on bit 1, beam-zero on bit 3, word-zero on bit 5, and data on bits 21:6.

Top module: `pattern_loop_seq`

## Requirements
- R1: After reset the controller is in IDLE with address 0, and `cable_word` shows the idle word: 0xFFFFFF when INVERT=1, 0x000000 when INVERT=0.
- R2: While `host_access` is high, a clock with `host_wr` high writes `host_wdata` at `host_addr`. `host_rdata` shows the word at the address presented one clock earlier.
- R3: While `host_access` is low, `host_wr` has no effect on the memory contents.
- R4: Count the clock edge that first samples `stream_en` high with `sync_wait` low as edge 1. The word at address 0 appears on `cable_word` after edge 3, and one further address appears per clock after that.
- R5: Playback covers addresses 0 through `loop_count`+2 and then wraps to 0. If that sum reaches the top of memory, the wrap happens at address 2^ADDR_W-1 instead.
- R6: Bits 0, 2, 4, 22 and 23 of `cable_word` are forced to 1 when INVERT=1 and to 0 when INVERT=0. All other bits equal the stored word.
- R7: Suppose `stream_en` is sampled low at an edge. The word fetched at that edge is still shown, and `cable_word` returns to the idle word on the following edge.
- R8: With `sync_wait` high, enable leads to ARM, which holds address 0 and shows idle. A `sync_pulse` sampled at an edge moves to RUN, and fetching from address 0 starts at the next edge.
- R9: Raising `host_access` stops playback at once. No word fetched at a host address is shown, and the controller stays in IDLE. Releasing host access with `stream_en` still high restarts playback from address 0.
- R10: `sw_reset` sampled at an edge forces IDLE, address 0 and the idle word at that edge, over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Software reset control bit |
| stream_en | input | 1 | Enable playback to the cable |
| sync_wait | input | 1 | Hold playback until a sync pulse |
| host_access | input | 1 | Give the pattern memory to the host |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | 24 | Host write data |
| host_rdata | output | 24 | Host read data, one clock latency |
| loop_count | input | ADDR_W | Looped locations minus three |
| sync_pulse | input | 1 | External beam-zero synchronisation pulse |
| cable_word | output | 24 | Registered word driving the cable |

## Verification
Playback runs with loop counts of 3, 0 and 5 over a memory holding ten distinct words, so that a wrong wrap point shows up as a word from beyond the loop. Every stored word is checked at both polarities at once, with filler bits set and cleared, which separates correct forcing from pass-through or whole-word inversion. Stop by disabling streaming, stop by taking host access, and stop by software reset each leave a different number of trailing words. Those counts distinguish where each stop takes effect. A sync-armed start checks that the idle span before the first word tracks the pulse rather than the enable.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int CABLE_W = 24;

    // positions that carry no signal and sit at the channel's idle level
    localparam logic [CABLE_W-1:0] FILL_MASK = 24'hC0_0015;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

    function automatic logic [CABLE_W-1:0] idle_word(input bit inv);
        return inv ? {CABLE_W{1'b1}} : {CABLE_W{1'b0}};
    endfunction

endpackage

// File: rtl/pattern_mem.sv
module pattern_mem #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
        rdata <= store[addr];
    end

endmodule

// File: rtl/loop_fsm.sv
module loop_fsm
    import seq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              stream_en,
    input  logic              sync_wait,
    input  logic              host_access,
    input  logic              sync_pulse,
    input  logic [ADDR_W-1:0] loop_count,
    output seq_state_t        state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              fetch_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] TOP_ADDR = (ADDR_W+1)'(DEPTH - 1);

    seq_state_t        state, state_nxt;
    logic [ADDR_W-1:0] addr, addr_nxt;
    logic [ADDR_W:0]   span;
    logic [ADDR_W-1:0] last;
    logic              halt;

    // loop end: count + 2, clipped at the top of memory
    always_comb begin
        span = {1'b0, loop_count} + (ADDR_W+1)'(2);
        last = (span >= TOP_ADDR) ? TOP_ADDR[ADDR_W-1:0] : span[ADDR_W-1:0];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            addr  <= '0;
        end else begin
            state <= state_nxt;
            addr  <= addr_nxt;
        end
    end

    // transitions
    always_comb begin
        halt      = !stream_en || host_access;
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (!halt) state_nxt = sync_wait ? ST_ARM : ST_RUN;
            ST_ARM: begin
                if (halt)            state_nxt = ST_IDLE;
                else if (sync_pulse) state_nxt = ST_RUN;
            end
            ST_RUN:  if (halt) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
        if (sw_reset) state_nxt = ST_IDLE;

        addr_nxt = '0;
        if (state == ST_RUN && state_nxt == ST_RUN) begin
            addr_nxt = (addr == last) ? '0 : addr + 1'b1;
        end
    end

    // outputs
    always_comb begin
        state_o = state;
        addr_o  = addr;
        fetch_o = (state == ST_RUN) && !host_access;
    end

endmodule

// File: rtl/cable_stage.sv
module cable_stage
    import seq_pkg::*;
#(
    parameter bit INVERT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_reset,
    input  logic               fetch,
    input  logic [CABLE_W-1:0] mem_word,
    output logic [CABLE_W-1:0] cable_word
);
    localparam logic [CABLE_W-1:0] IDLE_W = idle_word(INVERT);

    logic               vld;
    logic [CABLE_W-1:0] shaped;

    generate
        if (INVERT) begin : g_inv
            always_comb shaped = mem_word | FILL_MASK;
        end else begin : g_pos
            always_comb shaped = mem_word & ~FILL_MASK;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld        <= 1'b0;
            cable_word <= IDLE_W;
        end else if (sw_reset) begin
            vld        <= 1'b0;
            cable_word <= IDLE_W;
        end else begin
            vld        <= fetch;
            cable_word <= vld ? shaped : IDLE_W;
        end
    end

endmodule

// File: rtl/pattern_loop_seq.sv
module pattern_loop_seq
    import seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter bit INVERT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              stream_en,
    input  logic              sync_wait,
    input  logic              host_access,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [23:0]       host_wdata,
    output logic [23:0]       host_rdata,
    input  logic [ADDR_W-1:0] loop_count,
    input  logic              sync_pulse,
    output logic [23:0]       cable_word
);
    seq_state_t        state;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] mem_addr;
    logic              fetch;
    logic [23:0]       mem_rdata;

    // host and playback never share the port
    assign mem_addr   = host_access ? host_addr : seq_addr;
    assign host_rdata = mem_rdata;

    pattern_mem #(.ADDR_W(ADDR_W), .DATA_W(CABLE_W)) u_mem (
        .clk   (clk),
        .we    (host_access && host_wr),
        .addr  (mem_addr),
        .wdata (host_wdata),
        .rdata (mem_rdata)
    );

    loop_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_reset    (sw_reset),
        .stream_en   (stream_en),
        .sync_wait   (sync_wait),
        .host_access (host_access),
        .sync_pulse  (sync_pulse),
        .loop_count  (loop_count),
        .state_o     (state),
        .addr_o      (seq_addr),
        .fetch_o     (fetch)
    );

    cable_stage #(.INVERT(INVERT)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_reset   (sw_reset),
        .fetch      (fetch),
        .mem_word   (mem_rdata),
        .cable_word (cable_word)
    );

endmodule

// File: rtl/seq_chk.sv
module seq_chk
    import seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter bit INVERT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_reset,
    input logic              stream_en,
    input logic              host_access,
    input logic              sync_pulse,
    input logic [ADDR_W-1:0] loop_count,
    input seq_state_t        state,
    input logic [ADDR_W-1:0] seq_addr,
    input logic [23:0]       cable_word
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [23:0] IDLE_LVL = INVERT ? 24'hFFFFFF : 24'h000000;

    logic [ADDR_W:0]   sum;
    logic [ADDR_W-1:0] lim;
    always_comb begin
        sum = {1'b0, loop_count} + (ADDR_W+1)'(2);
        lim = (sum > (ADDR_W+1)'(DEPTH - 1)) ? ADDR_W'(DEPTH - 1) : sum[ADDR_W-1:0];
    end

    // R6
    filler_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cable_word & FILL_MASK) == (IDLE_LVL & FILL_MASK));

    // R5
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (seq_addr <= lim));

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && seq_addr == lim && stream_en && !host_access && !sw_reset)
        |=> (seq_addr == '0));

    // R8
    arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM) |-> (seq_addr == '0));

    // R8
    arm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && !sync_pulse && stream_en && !host_access && !sw_reset)
        |=> (state == ST_ARM));

    // R9
    host_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_access |=> (state == ST_IDLE));

    // R10
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (state == ST_IDLE && seq_addr == '0 && cable_word == IDLE_LVL));

endmodule

bind pattern_loop_seq seq_chk #(.ADDR_W(ADDR_W), .INVERT(INVERT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_reset    (sw_reset),
    .stream_en   (stream_en),
    .host_access (host_access),
    .sync_pulse  (sync_pulse),
    .loop_count  (loop_count),
    .state       (state),
    .seq_addr    (seq_addr),
    .cable_word  (cable_word)
);

// File: tb/test_pattern_loop_seq.sv
module test_pattern_loop_seq;
    localparam int AW = 10;
    localparam logic [23:0] FILL = 24'hC00015;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_reset = 0, stream_en = 0, sync_wait = 0;
    logic          host_access = 0, host_wr = 0, sync_pulse = 0;
    logic [AW-1:0] host_addr = '0, loop_count = '0;
    logic [23:0]   host_wdata = '0;
    logic [23:0]   rd_a, rd_b, cab_a, cab_b;

    always #5 clk = ~clk;

    pattern_loop_seq #(.ADDR_W(AW), .INVERT(1'b1)) i_pattern_loop_seq (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .stream_en(stream_en),
        .sync_wait(sync_wait), .host_access(host_access), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rd_a),
        .loop_count(loop_count), .sync_pulse(sync_pulse), .cable_word(cab_a));

    pattern_loop_seq #(.ADDR_W(AW), .INVERT(1'b0)) i_pattern_loop_seq_pos (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .stream_en(stream_en),
        .sync_wait(sync_wait), .host_access(host_access), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rd_b),
        .loop_count(loop_count), .sync_pulse(sync_pulse), .cable_word(cab_b));

    typedef struct packed { logic act; logic [23:0] raw; } item_t;
    item_t       exp_q[$];
    string       tag_q[$];
    logic [23:0] model [16];
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    task automatic chk(input bit ok, input string tg, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tg, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_idle(input int n, input string tg);
        for (int j = 0; j < n; j++) begin
            exp_q.push_back({1'b0, 24'h0});
            tag_q.push_back(tg);
        end
    endtask

    task automatic push_words(input int n, input int per, input string tg);
        for (int j = 0; j < n; j++) begin
            exp_q.push_back({1'b1, model[j % per]});
            tag_q.push_back(tg);
        end
    endtask

    task automatic drain;
        while (exp_q.size() != 0) @(negedge clk);
        tick(1);
    endtask

    // monitor: compares both polarities against each expected item
    initial begin
        item_t it;
        string tg;
        logic [23:0] ea, eb;
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() != 0) begin
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                ea = it.act ? (it.raw | FILL)  : 24'hFFFFFF;
                eb = it.act ? (it.raw & ~FILL) : 24'h000000;
                chk(cab_a == ea, {tg, " inv"}, cab_a, ea);
                chk(cab_b == eb, {tg, " pos"}, cab_b, eb);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 24'((i + 1) * 24'h2F3B71 ^ 24'h5A0C93);

        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state: idle words on both polarities
        chk(cab_a == 24'hFFFFFF, "R1 idle inv", cab_a, 24'hFFFFFF);
        chk(cab_b == 24'h000000, "R1 idle pos", cab_b, 24'h000000);

        // R2 host load
        host_access = 1;
        for (int i = 0; i < 10; i++) begin
            host_wr = 1; host_addr = AW'(i); host_wdata = model[i];
            tick(1);
        end
        host_wr = 0;
        for (int i = 0; i < 10; i++) begin
            host_addr = AW'(i);
            tick(1);
            chk(rd_a == model[i], "R2 readback", rd_a, model[i]);
        end
        // R3 write ignored without host access
        host_access = 0; host_wr = 1; host_addr = AW'(2); host_wdata = 24'h123456;
        tick(2);
        host_wr = 0; host_access = 1; host_addr = AW'(2);
        tick(1);
        chk(rd_a == model[2], "R3 write blocked", rd_a, model[2]);
        chk(rd_b == model[2], "R3 write blocked pos", rd_b, model[2]);
        host_access = 0;
        tick(2);

        // R4 R5 R6 R7: count 3 loops six words, then stop
        loop_count = AW'(3);
        tick(1);
        stream_en = 1;
        push_idle(2, "R4 start latency");
        push_words(14, 6, "R5 R6 loop of six");
        push_idle(2, "R7 stop");
        tick(14);
        stream_en = 0;
        drain();

        // R5: count 0 loops three words
        loop_count = AW'(0);
        tick(1);
        stream_en = 1;
        push_idle(2, "R4 start");
        push_words(7, 3, "R5 loop of three");
        push_idle(2, "R7 stop");
        tick(7);
        stream_en = 0;
        drain();

        // R5: count 5 loops eight words, words 8 and 9 must not appear
        loop_count = AW'(5);
        tick(1);
        stream_en = 1;
        push_idle(2, "R4 start");
        push_words(17, 8, "R5 loop of eight");
        push_idle(2, "R7 stop");
        tick(17);
        stream_en = 0;
        drain();

        // R8: armed start waits four clocks for the sync pulse
        loop_count = AW'(3);
        sync_wait = 1;
        tick(1);
        stream_en = 1;
        push_idle(6, "R8 armed hold");
        push_words(9, 6, "R8 after sync");
        push_idle(2, "R7 stop");
        tick(4);
        sync_pulse = 1;
        tick(1);
        sync_pulse = 0;
        tick(8);
        stream_en = 0;
        sync_wait = 0;
        drain();

        // R9: host access taken mid-run, then released
        tick(1);
        stream_en = 1;
        push_idle(2, "R9 start");
        push_words(5, 6, "R9 before host");
        push_idle(5, "R9 host blocks");
        push_words(6, 6, "R9 restart at 0");
        push_idle(2, "R7 stop");
        tick(6);
        host_access = 1; host_addr = AW'(9);
        tick(4);
        host_access = 0;
        tick(6);
        stream_en = 0;
        drain();

        // R10: software reset mid-run, then restart from address 0
        tick(1);
        stream_en = 1;
        push_idle(2, "R10 start");
        push_words(6, 6, "R10 before reset");
        push_idle(3, "R10 reset idle");
        tick(8);
        sw_reset = 1; stream_en = 0;
        tick(1);
        sw_reset = 0;
        drain();
        stream_en = 1;
        push_idle(2, "R10 restart");
        push_words(4, 6, "R10 restart at 0");
        push_idle(2, "R7 stop");
        tick(4);
        stream_en = 0;
        drain();

        finish_run();
    end

endmodule